// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands in the common single-precision layout and returns a 32-bit product one clock after the operands are presented. Each operand is split into sign, biased exponent and fraction, and the hidden leading one is restored. The two 24-bit significands are multiplied into a 48-bit product and the exponents are summed. The product is then normalised, rounded to nearest with ties to even, and packed back into a single word.

Special operands are resolved ahead of the arithmetic path. Quiet-NaN, infinity and zero results come out with the correct sign. Three flags report overflow, underflow and invalid operations. Subnormal inputs and results are not supported: an operand whose exponent field is zero counts as zero, and a result too small to be normal becomes zero.

The block sits in a datapath as a single pipeline stage with a valid qualifier. It has no back-pressure.

Top module: `fp32_mul_unit`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. The result and flags belong to the operands sampled at the same edge. In a cycle after `in_valid` was low, `result` and all flags are 0.
- R2: While `rst_n` is low, and until the first valid operation after reset, `out_valid`, `result` and every flag are 0.
- R3: Word fields are sign in bit 31, biased exponent in bits 30:23, and fraction in bits 22:0. For every result other than NaN, the sign bit is the XOR of the two operand sign bits.
- R4: Two normal operands give the product significand times 2 raised to the sum of the unbiased exponents, with a bias of 127. For example, 8.0 (0x41000000) times 10.5 (0x41280000) gives 84.0 (0x42A80000).
- R5: When the significand product is 2.0 or more, it is shifted right by one and the exponent is raised by one. For example, 1.5 × 1.5 gives 0x40100000.
- R6: The result is rounded to nearest, with ties to even. A round-up that carries out of the significand renormalises to the next exponent with a zero fraction.
- R7: If the rounded biased exponent reaches 255 or more, the result is an infinity with the product's sign (exponent 0xFF, fraction 0) and `flag_ovf` is 1.
- R8: If the rounded biased exponent is 0 or less, the result is a zero with the product's sign and `flag_unf` is 1.
- R9: Zero times infinity, in either order and with any signs, returns 0x7FC00000 with `flag_inv` set.
- R10: Any NaN operand (exponent 0xFF, fraction non-zero) returns 0x7FC00000 with no flag set. This rule takes priority over R9.
- R11: Infinity times a non-zero finite value gives a signed infinity. Zero times a finite value gives a signed zero. Neither case sets a flag.
- R12: An operand whose exponent field is 0 is treated as zero, whatever its fraction bits hold.
- R13: At most one of `flag_ovf`, `flag_unf` and `flag_inv` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are valid this cycle |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered product, single precision |
| flag_ovf | output | 1 | Product overflowed to infinity |
| flag_unf | output | 1 | Product underflowed to zero |
| flag_inv | output | 1 | Invalid operation (zero times infinity) |

## Verification
The bench targets the rounding edges:
- an exact tie with an odd last bit, which a truncating design leaves one unit low;
- an exact tie with an even last bit, which a round-half-up design bumps by one;
- a product of 2^47 − 1, whose round-up carries all the way to 2.0, which a design missing the renormalisation packs as 1.0 or as a wrapped fraction.

It drives the exponent limits:
- the largest finite value times 1.0 must not overflow;
- twice 2^127 must saturate to a signed infinity;
- the smallest normal value times 0.5 must flush to a signed zero.

A design with an off-by-one threshold or a lost sign fails one of these.

Among the special operands:
- zero times infinity checks that the invalid NaN appears;
- a NaN combined with zero checks NaN priority;
- a subnormal operand combined with infinity checks that a non-zero fraction under a zero exponent is ignored.

Thousands of random operand pairs are compared every clock against a behavioural model built on integer arithmetic.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_e;

    typedef struct packed {
        logic inv;
        logic ovf;
        logic unf;
    } fpm_flags_t;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output logic                  sign_o,
    output logic [EXP_W-1:0]      exp_o,
    output logic [FRAC_W:0]       sig_o,
    output fp_class_e             cls_o
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign sign_o = word_i[W-1];
    assign exp_f  = word_i[W-2 -: EXP_W];
    assign frac_f = word_i[FRAC_W-1:0];
    assign exp_o  = exp_f;
    // hidden one restored for normal values; flushed operands carry no significand
    assign sig_o  = {(exp_f != '0), frac_f};

    always_comb begin
        if (exp_f == '0)                       cls_o = CLS_ZERO;   // R12 flush
        else if (exp_f == '1 && frac_f == '0)  cls_o = CLS_INF;
        else if (exp_f == '1)                  cls_o = CLS_NAN;
        else                                   cls_o = CLS_NORM;
    end

endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
    parameter int FRAC_W = 23
) (
    input  logic [2*FRAC_W+1:0] prod_i,
    output logic [FRAC_W-1:0]   frac_o,
    output logic [1:0]          exp_inc_o
);
    localparam int PROD_W = 2 * (FRAC_W + 1);

    logic              top;
    logic [FRAC_W-1:0] mant;
    logic              g_bit;
    logic              r_bit;
    logic              s_bit;
    logic              up;
    logic [FRAC_W:0]   sum;

    assign top = prod_i[PROD_W-1];

    // R5: pick the window depending on whether the product reached 2.0
    always_comb begin
        if (top) begin
            mant  = prod_i[PROD_W-2 -: FRAC_W];
            g_bit = prod_i[PROD_W-2-FRAC_W];
            r_bit = prod_i[PROD_W-3-FRAC_W];
            s_bit = |prod_i[PROD_W-4-FRAC_W:0];
        end else begin
            mant  = prod_i[PROD_W-3 -: FRAC_W];
            g_bit = prod_i[PROD_W-3-FRAC_W];
            r_bit = prod_i[PROD_W-4-FRAC_W];
            s_bit = |prod_i[PROD_W-5-FRAC_W:0];
        end
    end

    // R6: nearest, ties to even
    assign up        = g_bit & (r_bit | s_bit | mant[0]);
    assign sum       = {1'b0, mant} + {{FRAC_W{1'b0}}, up};
    assign frac_o    = sum[FRAC_W-1:0];
    assign exp_inc_o = {1'b0, top} + {1'b0, sum[FRAC_W]};

endmodule

// File: rtl/fp32_mul_unit.sv
module fp32_mul_unit
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [EXP_W+FRAC_W:0]  op_a,
    input  logic [EXP_W+FRAC_W:0]  op_b,
    output logic                   out_valid,
    output logic [EXP_W+FRAC_W:0]  result,
    output logic                   flag_ovf,
    output logic                   flag_unf,
    output logic                   flag_inv
);
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EW     = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam logic signed [EW-1:0] E_BIAS = EW'(BIAS);
    localparam logic signed [EW-1:0] E_TOP  = EW'(EMAX);
    localparam logic signed [EW-1:0] E_ZERO = '0;
    localparam logic [W-2:0] MAG_INF  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [W-1:0] QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic       valid;
        logic [W-1:0] res;
        fpm_flags_t flg;
    } out_state_t;

    logic [W-1:0]      opw   [2];
    logic              sgn   [2];
    logic [EXP_W-1:0]  exv   [2];
    logic [FRAC_W:0]   sig   [2];
    fp_class_e         cls   [2];

    assign opw[0] = op_a;
    assign opw[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .word_i (opw[i]),
            .sign_o (sgn[i]),
            .exp_o  (exv[i]),
            .sig_o  (sig[i]),
            .cls_o  (cls[i])
        );
    end

    logic [PROD_W-1:0] prod;
    logic [FRAC_W-1:0] frac_r;
    logic [1:0]        inc;

    assign prod = sig[0] * sig[1];

    fpm_round #(.FRAC_W(FRAC_W)) u_round (
        .prod_i    (prod),
        .frac_o    (frac_r),
        .exp_inc_o (inc)
    );

    out_state_t        st_d, st_q;
    logic              s_prod;
    logic              any_nan, any_inf, any_zero;
    logic signed [EW-1:0] e_wide;

    always_comb begin
        s_prod   = sgn[0] ^ sgn[1];                                  // R3
        any_nan  = (cls[0] == CLS_NAN)  || (cls[1] == CLS_NAN);
        any_inf  = (cls[0] == CLS_INF)  || (cls[1] == CLS_INF);
        any_zero = (cls[0] == CLS_ZERO) || (cls[1] == CLS_ZERO);
        // R4: biased sum of exponents plus normalisation/rounding adjustments
        e_wide   = $signed({2'b00, exv[0]}) + $signed({2'b00, exv[1]})
                 + $signed({{EXP_W{1'b0}}, inc}) - E_BIAS;

        st_d       = '0;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (any_nan) begin
                st_d.res = QNAN;                                     // R10
            end else if (any_inf && any_zero) begin
                st_d.res     = QNAN;                                 // R9
                st_d.flg.inv = 1'b1;
            end else if (any_inf) begin
                st_d.res = {s_prod, MAG_INF};                        // R11
            end else if (any_zero) begin
                st_d.res = {s_prod, {(W-1){1'b0}}};                  // R11
            end else if (e_wide >= E_TOP) begin
                st_d.res     = {s_prod, MAG_INF};                    // R7
                st_d.flg.ovf = 1'b1;
            end else if (e_wide <= E_ZERO) begin
                st_d.res     = {s_prod, {(W-1){1'b0}}};              // R8
                st_d.flg.unf = 1'b1;
            end else begin
                st_d.res = {s_prod, e_wide[EXP_W-1:0], frac_r};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;                                      // R2
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign flag_ovf  = st_q.flg.ovf;
    assign flag_unf  = st_q.flg.unf;
    assign flag_inv  = st_q.flg.inv;

    // ---- assertions ----
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && result == '0 && !flag_ovf && !flag_unf && !flag_inv));

    p_sign_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[W-2 -: EXP_W] != '1) |-> result[W-1] == $past(op_a[W-1] ^ op_b[W-1]));

    p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ovf |-> (out_valid && result[W-2:0] == MAG_INF));

    p_unf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_unf |-> (out_valid && result[W-2:0] == '0));

    p_inv_qnan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inv |-> result == QNAN);

    p_flag_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_ovf, flag_unf, flag_inv}));

endmodule

// File: tb/sim_fp32_mul_unit.sv
`timescale 1ns/1ps
module sim_fp32_mul_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_ovf, flag_unf, flag_inv;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fp32_mul_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .result(result), .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inv(flag_inv)
    );

    // behavioural reference: {inv, ovf, unf, word}
    function automatic logic [34:0] ref_mul(logic [31:0] a, logic [31:0] b);
        int ea, eb, k, e;
        bit s, za, zb, ia, ib, na, nb;
        longint p, q, rem, half;
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        s  = a[31] ^ b[31];
        za = (ea == 0);
        zb = (eb == 0);
        ia = (ea == 255) && (a[22:0] == 0);
        ib = (eb == 255) && (b[22:0] == 0);
        na = (ea == 255) && (a[22:0] != 0);
        nb = (eb == 255) && (b[22:0] != 0);
        if (na || nb) return {3'b000, 32'h7FC00000};
        if ((za && ib) || (zb && ia)) return {3'b100, 32'h7FC00000};
        if (ia || ib) return {3'b000, s, 31'h7F800000};
        if (za || zb) return {3'b000, s, 31'h0};
        p = (longint'(a[22:0]) + 64'sd8388608) * (longint'(b[22:0]) + 64'sd8388608);
        k = 23;
        while ((p >> k) >= 64'sd16777216) k++;
        q    = p >> k;
        rem  = p - (q << k);
        half = 64'sd1 << (k - 1);
        if (rem > half || (rem == half && q[0])) q++;
        if (q == 64'sd16777216) begin
            q = q >> 1;
            k++;
        end
        e = ea + eb - 127 + (k - 23);
        if (e >= 255) return {3'b010, s, 31'h7F800000};
        if (e <= 0)   return {3'b001, s, 31'h0};
        return {3'b000, s, e[7:0], q[22:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // drive one operand pair, then compare one clock later (at the next falling edge)
    task automatic vec(logic [31:0] a, logic [31:0] b, logic [31:0] er, logic [2:0] ef, string tag);
        in_valid = 1'b1;
        op_a     = a;
        op_b     = b;
        @(negedge clk);
        chk({tag, " valid"},  {31'd0, out_valid}, 32'd1);
        chk({tag, " result"}, result, er);
        chk({tag, " flags"},  {29'd0, flag_inv, flag_ovf, flag_unf}, {29'd0, ef});
    endtask

    task automatic rvec(logic [31:0] a, logic [31:0] b);
        logic [34:0] r;
        r = ref_mul(a, b);
        vec(a, b, r[31:0], r[34:32], "random R4 R6 model");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        chk("R2 reset result", result, 32'h0);
        chk("R2 reset valid/flags", {28'd0, out_valid, flag_inv, flag_ovf, flag_unf}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 after release", {result[30:0], out_valid}, 32'd0);

        vec(32'h41000000, 32'h41280000, 32'h42A80000, 3'b000, "R4 8x10.5");
        vec(32'hC1000000, 32'h41280000, 32'hC2A80000, 3'b000, "R3 sign xor");
        vec(32'hC0000000, 32'hC0400000, 32'h40C00000, 3'b000, "R3 neg x neg");
        vec(32'h3FC00000, 32'h3FC00000, 32'h40100000, 3'b000, "R5 1.5x1.5");
        vec(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000, "R6 tie odd up");
        vec(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000, "R6 tie even stays");
        vec(32'h3FA1E58F, 32'h3FCA6691, 32'h40000000, 3'b000, "R6 carry renorm");
        vec(32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 3'b000, "R7 max finite no ovf");
        vec(32'h7F000000, 32'h40000000, 32'h7F800000, 3'b010, "R7 overflow pos");
        vec(32'hFF000000, 32'h40000000, 32'hFF800000, 3'b010, "R7 overflow neg");
        vec(32'h00800000, 32'h3F800000, 32'h00800000, 3'b000, "R8 min normal kept");
        vec(32'h00800000, 32'h3F000000, 32'h00000000, 3'b001, "R8 underflow pos");
        vec(32'h80800000, 32'h3F000000, 32'h80000000, 3'b001, "R8 underflow neg");
        vec(32'h00000000, 32'h7F800000, 32'h7FC00000, 3'b100, "R9 zero x inf");
        vec(32'hFF800000, 32'h80000000, 32'h7FC00000, 3'b100, "R9 inf x negzero");
        vec(32'h7FC12345, 32'h3F800000, 32'h7FC00000, 3'b000, "R10 nan x one");
        vec(32'h00000000, 32'hFF812345, 32'h7FC00000, 3'b000, "R10 nan priority");
        vec(32'h7F800000, 32'hC0000000, 32'hFF800000, 3'b000, "R11 inf x -2");
        vec(32'h00000000, 32'hC0400000, 32'h80000000, 3'b000, "R11 zero x -3");
        vec(32'h00400000, 32'h40000000, 32'h00000000, 3'b000, "R12 subnormal flush");
        vec(32'h00000001, 32'h7F800000, 32'h7FC00000, 3'b100, "R12 subnormal x inf");

        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle valid/flags", {28'd0, out_valid, flag_inv, flag_ovf, flag_unf}, 32'd0);
        chk("R1 idle result", result, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i < 2000) begin
                a[30:23] = 8'(100 + ($urandom % 55));
                b[30:23] = 8'(100 + ($urandom % 55));
            end
            rvec(a, b);
            // R13: at most one flag
            checks++;
            if ($countones({flag_inv, flag_ovf, flag_unf}) > 1) begin
                errors++;
                $display("FAIL R13 flags: actual %b expected one-hot or none",
                         {flag_inv, flag_ovf, flag_unf});
            end
        end

        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 final idle", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule